// File: doc/BRIEF.md
# Source-ID Qualified Bus Trace Capture

This block is a debug observer for a multiplexed external local bus. Its drive side turns the internal 5-bit identifier of the transaction source into a source-ID output. That output carries the identifier while an address or a data word is valid on the bus. At all other times it carries the reserved all-ones code, which means "nothing valid".

Its capture side watches the source-ID lines, the address latch strobe, the data valid strobe, the 16 multiplexed address/data lines and the 10 upper address lines. All of these are registered once. In the following cycle the registered copy is classified. A strobe that comes with a valid identifier produces a trace entry. Each entry holds a type flag, the identifier and a 26-bit payload, and it enters an 8-entry FIFO. A host drains the FIFO through a valid/ready port.

A strobe that comes with the reserved code produces no entry. It is counted in a saturating counter instead. When the FIFO has no room, the entry is discarded and a sticky overflow flag is set.

Top module: `srct_top`

## Requirements
- R1: `src_id_o` equals `txn_id` whenever `addr_phase` or `data_phase` is high, and equals 5'h1F otherwise.
- R2: A capture cycle whose registered `obs_id` is 5'h1F produces no FIFO entry, whatever the strobes are.
- R3: A capture cycle with a valid `obs_id` and `obs_ale` high produces an address entry. Its fields are `rd_is_data`=0, `rd_id`=`obs_id` and `rd_payload`={`obs_ad`,`obs_ua`}. Address bit 0 (the MSB) is therefore `obs_ad[15]`, and address bit 25 is `obs_ua[0]`.
- R4: A capture cycle with a valid `obs_id` and `obs_dval` high produces a data entry. Its fields are `rd_is_data`=1, `rd_id`=`obs_id` and `rd_payload`={10'b0,`obs_ad`}.
- R5: When both strobes are high with a valid ID, the address entry is queued ahead of the data entry.
- R6: Inputs sampled at rising edge k produce an entry that is readable on the read port after edge k+1.
- R7: `drop_count` rises by one for every capture cycle that has a strobe and an ID of 5'h1F. It saturates at 255.
- R8: Entries leave in arrival order. One entry is removed on each edge where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, the head entry holds steady.
- R9: The FIFO holds 8 entries. When it is full, a new entry is discarded and `overflow` is set. When one slot is free and both strobes arrive, the address entry is kept and the data entry is discarded.
- R10: `overflow` stays set until an edge with `ovf_clear` high clears it. A discard on that same edge keeps it set.
- R11: Synchronous reset empties the FIFO (`rd_valid`=0), zeroes `drop_count` and clears `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_id | input | 5 | Internal ID of the current transaction source |
| addr_phase | input | 1 | Valid address present on the bus |
| data_phase | input | 1 | Valid data present on the bus |
| src_id_o | output | 5 | Source ID presented to the bus, 5'h1F when idle |
| obs_id | input | 5 | Observed source-ID lines |
| obs_ale | input | 1 | Observed address latch strobe |
| obs_dval | input | 1 | Observed data valid strobe |
| obs_ad | input | 16 | Observed multiplexed address/data lines, bit 15 = bus bit 0 |
| obs_ua | input | 10 | Observed upper address lines, bit 9 = address bit 16 |
| rd_valid | output | 1 | Trace entry available |
| rd_ready | input | 1 | Host accepts the head entry |
| rd_is_data | output | 1 | Head entry type: 0 address, 1 data |
| rd_id | output | 5 | Head entry source ID |
| rd_payload | output | 26 | Head entry payload |
| overflow | output | 1 | Sticky flag: an entry was discarded |
| ovf_clear | input | 1 | Clears `overflow` |
| drop_count | output | 8 | Saturating count of strobes seen with the invalid ID |

## Verification
A wrong classification shows up at the read port two edges after the stimulus. It can appear as a missing entry, an extra entry, a swapped type flag or a misplaced payload half. Each scenario in the bench drains the FIFO completely, so a missing or extra entry is caught in that same scenario. A wrong pointer or occupancy count gives entries out of order or a wrong empty state. The test that fills the FIFO, overflows it and then drains it exposes this within about twenty cycles. A wrong drop counter shows up directly on `drop_count`, and its saturation is driven past 255.

// File: rtl/srct_pkg.sv
package srct_pkg;
    localparam int ID_W   = 5;
    localparam int AD_W   = 16;
    localparam int UA_W   = 10;
    localparam int ADDR_W = AD_W + UA_W;
    localparam logic [ID_W-1:0] ID_NONE = '1;

    typedef struct packed {
        logic              is_data;
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] payload;
    } trace_ent_t;
endpackage

// File: rtl/srct_id_drive.sv
module srct_id_drive
    import srct_pkg::*;
(
    input  logic [ID_W-1:0] txn_id,
    input  logic            addr_phase,
    input  logic            data_phase,
    output logic [ID_W-1:0] src_id
);
    always_comb begin
        src_id = (addr_phase || data_phase) ? txn_id : ID_NONE;
    end
endmodule

// File: rtl/srct_capture.sv
module srct_capture
    import srct_pkg::*;
#(
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ID_W-1:0]   obs_id,
    input  logic              obs_ale,
    input  logic              obs_dval,
    input  logic [AD_W-1:0]   obs_ad,
    input  logic [UA_W-1:0]   obs_ua,
    output logic              push0,
    output trace_ent_t        ent0,
    output logic              push1,
    output trace_ent_t        ent1,
    output logic [DROP_W-1:0] drop_count
);
    logic [ID_W-1:0] stg_id;
    logic            stg_ale, stg_dval;
    logic [AD_W-1:0] stg_ad;
    logic [UA_W-1:0] stg_ua;
    logic            id_ok;
    trace_ent_t      addr_ent, data_ent;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_id   <= ID_NONE;
            stg_ale  <= 1'b0;
            stg_dval <= 1'b0;
            stg_ad   <= '0;
            stg_ua   <= '0;
        end else begin
            stg_id   <= obs_id;
            stg_ale  <= obs_ale;
            stg_dval <= obs_dval;
            stg_ad   <= obs_ad;
            stg_ua   <= obs_ua;
        end
    end

    always_comb begin
        id_ok            = (stg_id != ID_NONE);
        addr_ent.is_data = 1'b0;
        addr_ent.id      = stg_id;
        addr_ent.payload = {stg_ad, stg_ua};
        data_ent.is_data = 1'b1;
        data_ent.id      = stg_id;
        data_ent.payload = {{UA_W{1'b0}}, stg_ad};
        push0 = 1'b0;
        push1 = 1'b0;
        ent0  = addr_ent;
        ent1  = data_ent;
        if (id_ok) begin
            if (stg_ale) begin
                push0 = 1'b1;
                push1 = stg_dval;
            end else if (stg_dval) begin
                push0 = 1'b1;
                ent0  = data_ent;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drop_count <= '0;
        end else if (!id_ok && (stg_ale || stg_dval) && (drop_count != '1)) begin
            drop_count <= drop_count + DROP_W'(1);
        end
    end
endmodule

// File: rtl/srct_fifo.sv
module srct_fifo
    import srct_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push0,
    input  trace_ent_t ent0,
    input  logic       push1,
    input  trace_ent_t ent1,
    input  logic       rd_ready,
    output logic       rd_valid,
    output trace_ent_t head,
    input  logic       ovf_clear,
    output logic       overflow
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    trace_ent_t       mem [DEPTH];
    logic [PTR_W-1:0] wp, rp, wp_next;
    logic [CNT_W-1:0] count, free;
    logic             acc0, acc1, lost, pop;

    always_comb begin
        free     = CNT_W'(DEPTH) - count;
        acc0     = push0 && (free != '0);
        acc1     = push1 && (free >= CNT_W'(2));
        lost     = (push0 && !acc0) || (push1 && !acc1);
        rd_valid = (count != '0);
        pop      = rd_valid && rd_ready;
        wp_next  = wp + PTR_W'(1);
        head     = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (acc0) mem[wp] <= ent0;
        if (acc1) mem[wp_next] <= ent1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp       <= '0;
            rp       <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            wp    <= wp + PTR_W'(acc0) + PTR_W'(acc1);
            rp    <= rp + PTR_W'(pop);
            count <= count + CNT_W'(acc0) + CNT_W'(acc1) - CNT_W'(pop);
            if (lost)           overflow <= 1'b1;
            else if (ovf_clear) overflow <= 1'b0;
        end
    end
endmodule

// File: rtl/srct_top.sv
module srct_top
    import srct_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        txn_id,
    input  logic              addr_phase,
    input  logic              data_phase,
    output logic [4:0]        src_id_o,
    input  logic [4:0]        obs_id,
    input  logic              obs_ale,
    input  logic              obs_dval,
    input  logic [15:0]       obs_ad,
    input  logic [9:0]        obs_ua,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic              rd_is_data,
    output logic [4:0]        rd_id,
    output logic [25:0]       rd_payload,
    output logic              overflow,
    input  logic              ovf_clear,
    output logic [DROP_W-1:0] drop_count
);
    logic       push0, push1;
    trace_ent_t ent0, ent1, head;

    srct_id_drive u_drive (
        .txn_id     (txn_id),
        .addr_phase (addr_phase),
        .data_phase (data_phase),
        .src_id     (src_id_o)
    );

    srct_capture #(.DROP_W(DROP_W)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .obs_id     (obs_id),
        .obs_ale    (obs_ale),
        .obs_dval   (obs_dval),
        .obs_ad     (obs_ad),
        .obs_ua     (obs_ua),
        .push0      (push0),
        .ent0       (ent0),
        .push1      (push1),
        .ent1       (ent1),
        .drop_count (drop_count)
    );

    srct_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push0     (push0),
        .ent0      (ent0),
        .push1     (push1),
        .ent1      (ent1),
        .rd_ready  (rd_ready),
        .rd_valid  (rd_valid),
        .head      (head),
        .ovf_clear (ovf_clear),
        .overflow  (overflow)
    );

    assign rd_is_data = head.is_data;
    assign rd_id      = head.id;
    assign rd_payload = head.payload;
endmodule

// File: rtl/srct_chk.sv
module srct_chk #(
    parameter int DROP_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [4:0]        txn_id,
    input logic              addr_phase,
    input logic              data_phase,
    input logic [4:0]        src_id_o,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic              rd_is_data,
    input logic [4:0]        rd_id,
    input logic [25:0]       rd_payload,
    input logic              overflow,
    input logic              ovf_clear,
    input logic [DROP_W-1:0] drop_count
);
    // R1
    idle_code_chk: assert property (@(posedge clk) disable iff (rst)
        !(addr_phase || data_phase) |-> src_id_o == 5'h1F);
    // R1
    pass_id_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_phase || data_phase) |-> src_id_o == txn_id);
    // R7
    drop_sat_chk: assert property (@(posedge clk) disable iff (rst)
        drop_count == '1 |=> drop_count == '1);
    // R7
    drop_mono_chk: assert property (@(posedge clk) disable iff (rst)
        drop_count != '1 |=> (drop_count == $past(drop_count)) ||
                             (drop_count == $past(drop_count) + DROP_W'(1)));
    // R8
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_payload) &&
                                  $stable(rd_id) && $stable(rd_is_data));
    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow && !ovf_clear |=> overflow);
    // R11
    reset_state_chk: assert property (@(posedge clk)
        rst |=> !rd_valid && !overflow && drop_count == '0);
endmodule

bind srct_top srct_chk #(.DROP_W(DROP_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .txn_id     (txn_id),
    .addr_phase (addr_phase),
    .data_phase (data_phase),
    .src_id_o   (src_id_o),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_is_data (rd_is_data),
    .rd_id      (rd_id),
    .rd_payload (rd_payload),
    .overflow   (overflow),
    .ovf_clear  (ovf_clear),
    .drop_count (drop_count)
);

// File: tb/srct_top_tb_top.sv
module srct_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  txn_id = '0;
    logic        addr_phase = 1'b0, data_phase = 1'b0;
    logic [4:0]  src_id_o;
    logic [4:0]  obs_id = 5'h1F;
    logic        obs_ale = 1'b0, obs_dval = 1'b0;
    logic [15:0] obs_ad = '0;
    logic [9:0]  obs_ua = '0;
    logic        rd_valid, rd_ready = 1'b0, rd_is_data;
    logic [4:0]  rd_id;
    logic [25:0] rd_payload;
    logic        overflow, ovf_clear = 1'b0;
    logic [7:0]  drop_count;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    srct_top dut_i (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one capture cycle; returns after the entry is readable (R6).
    task automatic present(logic [4:0] id, logic ale, logic dv,
                           logic [15:0] ad, logic [9:0] ua);
        @(negedge clk);
        obs_id = id; obs_ale = ale; obs_dval = dv; obs_ad = ad; obs_ua = ua;
        @(negedge clk);
        obs_id = 5'h1F; obs_ale = 1'b0; obs_dval = 1'b0;
        @(negedge clk);
    endtask

    task automatic pop_expect(string tag, logic isd, logic [4:0] id, logic [25:0] pl);
        chk({tag, " valid"}, 32'(rd_valid), 32'd1);
        chk({tag, " type"}, 32'(rd_is_data), 32'(isd));
        chk({tag, " id"}, 32'(rd_id), 32'(id));
        chk({tag, " payload"}, 32'(rd_payload), 32'(pl));
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 rd_valid", 32'(rd_valid), 0);
        chk("R11 overflow", 32'(overflow), 0);
        chk("R11 drop_count", 32'(drop_count), 0);
    endtask

    task automatic t_drive();
        @(negedge clk);
        txn_id = 5'h0A; addr_phase = 1'b1; data_phase = 1'b0; #1;
        chk("R1 addr phase", 32'(src_id_o), 32'h0A);
        addr_phase = 1'b0; data_phase = 1'b1; txn_id = 5'h13; #1;
        chk("R1 data phase", 32'(src_id_o), 32'h13);
        data_phase = 1'b0; #1;
        chk("R1 idle", 32'(src_id_o), 32'h1F);
    endtask

    task automatic t_addr();
        // 2 edges after sampling: entry present (R6)
        @(negedge clk);
        obs_id = 5'h03; obs_ale = 1'b1; obs_ad = 16'h8001; obs_ua = 10'h201;
        @(negedge clk);
        obs_id = 5'h1F; obs_ale = 1'b0;
        chk("R6 not yet readable", 32'(rd_valid), 0);
        @(negedge clk);
        pop_expect("R3 addr", 1'b0, 5'h03, {16'h8001, 10'h201});
        chk("R3 empty after", 32'(rd_valid), 0);
    endtask

    task automatic t_data();
        present(5'h00, 1'b0, 1'b1, 16'hBEEF, 10'h3FF);
        pop_expect("R4 data", 1'b1, 5'h00, {10'h0, 16'hBEEF});
        chk("R4 empty after", 32'(rd_valid), 0);
    endtask

    task automatic t_both();
        present(5'h1E, 1'b1, 1'b1, 16'h1234, 10'h155);
        pop_expect("R5 first addr", 1'b0, 5'h1E, {16'h1234, 10'h155});
        pop_expect("R5 second data", 1'b1, 5'h1E, {10'h0, 16'h1234});
        chk("R5 empty after", 32'(rd_valid), 0);
    endtask

    task automatic t_invalid();
        present(5'h1F, 1'b1, 1'b0, 16'h1111, 10'h1);
        present(5'h1F, 1'b1, 1'b1, 16'h2222, 10'h2);
        chk("R2 nothing queued", 32'(rd_valid), 0);
        chk("R7 two drops", 32'(drop_count), 2);
    endtask

    task automatic t_hold();
        present(5'h05, 1'b0, 1'b1, 16'hAAAA, 10'h0);
        present(5'h06, 1'b0, 1'b1, 16'h5555, 10'h0);
        repeat (3) @(negedge clk);
        chk("R8 head held id", 32'(rd_id), 32'h05);
        pop_expect("R8 order 1", 1'b1, 5'h05, {10'h0, 16'hAAAA});
        pop_expect("R8 order 2", 1'b1, 5'h06, {10'h0, 16'h5555});
        chk("R8 drained", 32'(rd_valid), 0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 8; i++) present(5'(i), 1'b0, 1'b1, 16'(i + 100), 10'h0);
        chk("R9 no ovf at 8", 32'(overflow), 0);
        present(5'h09, 1'b1, 1'b0, 16'hFFFF, 10'h3FF);
        chk("R9 ovf set", 32'(overflow), 1);
        for (int i = 0; i < 8; i++)
            pop_expect("R9 kept entry", 1'b1, 5'(i), {10'h0, 16'(i + 100)});
        chk("R9 ninth discarded", 32'(rd_valid), 0);
        repeat (2) @(negedge clk);
        chk("R10 sticky", 32'(overflow), 1);
        ovf_clear = 1'b1;
        @(negedge clk);
        ovf_clear = 1'b0;
        chk("R10 cleared", 32'(overflow), 0);
        for (int i = 0; i < 7; i++) present(5'h01, 1'b0, 1'b1, 16'(i), 10'h0);
        present(5'h02, 1'b1, 1'b1, 16'hC0DE, 10'h0AB);
        chk("R9 partial ovf", 32'(overflow), 1);
        for (int i = 0; i < 7; i++)
            pop_expect("R9 partial keep", 1'b1, 5'h01, {10'h0, 16'(i)});
        pop_expect("R9 addr kept", 1'b0, 5'h02, {16'hC0DE, 10'h0AB});
        chk("R9 data dropped", 32'(rd_valid), 0);
        ovf_clear = 1'b1;
        @(negedge clk);
        ovf_clear = 1'b0;
    endtask

    task automatic t_saturate();
        @(negedge clk);
        obs_id = 5'h1F; obs_dval = 1'b1;
        repeat (300) @(negedge clk);
        obs_dval = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 saturated", 32'(drop_count), 255);
        chk("R2 no entry", 32'(rd_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_drive();
        t_addr();
        t_data();
        t_both();
        t_invalid();
        t_hold();
        t_overflow();
        t_saturate();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule